// File: doc/BRIEF.md
# Packet Stream Width Doubler

This block sits between a producer of 64-bit packet beats and a consumer that takes 128-bit beats. It gathers two consecutive narrow beats into one wide beat, the first beat in the upper half of the word and the second in the lower half. Every beat carries framing flags (start, end, error), a count of unused bytes in the final beat, and an 8-bit channel tag. A packet that ends on the first half of a pair is sent out at once as a half-filled word. If the channel tag changes between the two halves of a pair, the wide beat is marked with an error and an end of packet.

One read-enable from the consumer gates all of the block's state. The read-enable is also handed back to the producer, so the same block works when the producer pushes beats (read-enable tied high) and when the consumer pops them. The space and data availability flags pass straight through the block and take no part in the pairing. All wide-side outputs are registered.

Top module: `pkt_upsizer`

## Requirements
- R1: `out_rd_avail` follows `in_rd_avail` and `in_wr_room` follows `out_wr_room` combinationally, with no clock involved.
- R2: `in_rd_en` follows `out_rd_en` combinationally.
- R3: In a cycle where `out_rd_en` is low, no output changes and any narrow beat offered is not consumed.
- R4: An enabled narrow beat without end of packet that arrives while the upper half is empty is stored in the upper half and produces no wide beat (`out_wr_en` low on the next cycle).
- R5: An enabled narrow beat that arrives while the upper half is held completes a wide beat one cycle later: `out_data[127:64]` is the stored beat, `out_data[63:0]` the new beat, and `out_sop` and `out_addr` come from the stored beat.
- R6: An enabled beat with end of packet that arrives while the upper half is empty is sent alone: `out_data[127:64]` is the beat, `out_data[63:0]` is zero, `out_eop` is 1 and `out_empty` equals the input empty count plus 8.
- R7: For a completed pair, `out_empty` equals the input empty count of the second beat when that beat ends the packet, and is 0 with `out_eop` low when neither beat ends it.
- R8: When the second beat's channel tag differs from the stored tag, the wide beat has `out_err` and `out_eop` both set.
- R9: An error flag on either narrow beat of a pair sets `out_err` on the wide beat.
- R10: After a channel-tag mismatch, the next wide beat produced also has `out_err` set. The wide beat after that one does not have it unless a new error occurs.
- R11: After any wide beat is produced, pairing restarts, so the next narrow beat goes to the upper half.
- R12: In an enabled cycle with `in_wr_en` low, `out_wr_en` is low on the next cycle.
- R13: While `rst` is high, on each clock `out_wr_en`, `out_sop`, `out_eop`, `out_err` and `out_empty` clear and the upper half becomes empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_rd_avail | input | 1 | Producer has data available |
| in_wr_room | output | 1 | Consumer room flag passed back to producer |
| in_rd_en | output | 1 | Read-enable passed to producer |
| in_wr_en | input | 1 | Narrow beat valid |
| in_sop | input | 1 | Narrow start of packet |
| in_eop | input | 1 | Narrow end of packet |
| in_err | input | 1 | Narrow error flag |
| in_data | input | 64 | Narrow data |
| in_empty | input | 3 | Unused bytes in narrow end beat |
| in_addr | input | 8 | Narrow channel tag |
| out_rd_avail | output | 1 | Producer availability passed to consumer |
| out_wr_room | input | 1 | Consumer has room |
| out_rd_en | input | 1 | Consumer read-enable, gates all state |
| out_wr_en | output | 1 | Wide beat valid |
| out_sop | output | 1 | Wide start of packet |
| out_eop | output | 1 | Wide end of packet |
| out_err | output | 1 | Wide error flag |
| out_data | output | 128 | Wide data |
| out_empty | output | 4 | Unused bytes in wide end beat |
| out_addr | output | 8 | Wide channel tag |

## Verification
Two pairs of functions can land in one cycle. The first pair is a channel-tag mismatch and the pending error from an earlier mismatch. The second pair is an end-of-packet flush and the restart of pairing. The bench first sends a pair whose second beat changes the tag. It then sends a follow-up pair and checks that the follow-up carries the repeated error and that the pair after it is clean. It also flushes a single end-of-packet beat and then sends one lone beat, checking that this beat is stored without a wide write. The bench also offers a beat while the read-enable is low and checks that the held outputs do not move and that the next pair is assembled without that beat.

// File: rtl/upsz_pkg.sv
package upsz_pkg;
  localparam int unsigned NARROW_W_DEF = 64;
  localparam int unsigned CHAN_W_DEF   = 8;

  typedef enum logic {
    SLOT_OPEN = 1'b0,
    SLOT_HELD = 1'b1
  } slot_e;
endpackage

// File: rtl/upsz_half_store.sv
module upsz_half_store
  import upsz_pkg::*;
#(
  parameter int unsigned DW = NARROW_W_DEF,
  parameter int unsigned AW = CHAN_W_DEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic          take,
  input  logic          drop,
  input  logic [DW-1:0] d_data,
  input  logic          d_sop,
  input  logic          d_err,
  input  logic [AW-1:0] d_addr,
  output slot_e         slot,
  output logic [DW-1:0] h_data,
  output logic          h_sop,
  output logic          h_err,
  output logic [AW-1:0] h_addr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot <= SLOT_OPEN;
    end else if (ce) begin
      if (take)      slot <= SLOT_HELD;
      else if (drop) slot <= SLOT_OPEN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_sop  <= 1'b0;
      h_err  <= 1'b0;
      h_addr <= '0;
    end else if (ce && take) begin
      h_sop  <= d_sop;
      h_err  <= d_err;
      h_addr <= d_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (ce && take) h_data <= d_data;
  end

  p_take_drop_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(ce && take && drop));

  p_slot_frozen_r3: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(slot));

endmodule

// File: rtl/upsz_err_track.sv
module upsz_err_track #(
  parameter bit STICKY = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic ce,
  input  logic mismatch,
  input  logic emit,
  output logic pend
);

  generate
    if (STICKY) begin : g_sticky
      always_ff @(posedge clk) begin
        if (rst)              pend <= 1'b0;
        else if (ce) begin
          if (mismatch)       pend <= 1'b1;
          else if (emit)      pend <= 1'b0;
        end
      end

      p_sticky_set_r10: assert property (@(posedge clk) disable iff (rst)
        (ce && mismatch) |=> pend);
    end else begin : g_plain
      assign pend = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/upsz_word_build.sv
module upsz_word_build
  import upsz_pkg::*;
#(
  parameter int unsigned DW  = NARROW_W_DEF,
  parameter int unsigned AW  = CHAN_W_DEF,
  parameter int unsigned EWI = $clog2(DW/8),
  parameter int unsigned EWO = EWI + 1
) (
  input  logic           beat_vld,
  input  logic [DW-1:0]  b_data,
  input  logic           b_sop,
  input  logic           b_eop,
  input  logic           b_err,
  input  logic [EWI-1:0] b_empty,
  input  logic [AW-1:0]  b_addr,
  input  slot_e          slot,
  input  logic [DW-1:0]  h_data,
  input  logic           h_sop,
  input  logic           h_err,
  input  logic [AW-1:0]  h_addr,
  input  logic           pend,
  output logic           take,
  output logic           drop,
  output logic           emit,
  output logic           mismatch,
  output logic [2*DW-1:0] w_data,
  output logic           w_sop,
  output logic           w_eop,
  output logic           w_err,
  output logic [EWO-1:0] w_empty,
  output logic [AW-1:0]  w_addr
);

  localparam logic [EWO-1:0] HALF_BYTES = EWO'(DW/8);

  always_comb begin
    take     = 1'b0;
    drop     = 1'b0;
    emit     = 1'b0;
    mismatch = 1'b0;
    w_data   = {h_data, b_data};
    w_sop    = h_sop;
    w_addr   = h_addr;
    w_eop    = 1'b0;
    w_err    = 1'b0;
    w_empty  = '0;
    if (beat_vld) begin
      if (slot == SLOT_OPEN) begin
        if (b_eop) begin
          emit    = 1'b1;
          w_data  = {b_data, {DW{1'b0}}};
          w_sop   = b_sop;
          w_addr  = b_addr;
          w_eop   = 1'b1;
          w_err   = b_err | pend;
          w_empty = {1'b0, b_empty} + HALF_BYTES;
        end else begin
          take = 1'b1;
        end
      end else begin
        emit     = 1'b1;
        drop     = 1'b1;
        mismatch = (b_addr != h_addr);
        w_eop    = b_eop | mismatch;
        w_err    = h_err | b_err | mismatch | pend;
        w_empty  = b_eop ? {1'b0, b_empty} : '0;
      end
    end
  end

endmodule

// File: rtl/pkt_upsizer.sv
module pkt_upsizer
  import upsz_pkg::*;
#(
  parameter int unsigned NARROW_W = NARROW_W_DEF,
  parameter int unsigned CHAN_W   = CHAN_W_DEF,
  parameter bit          STICKY   = 1'b1,
  parameter int unsigned WIDE_W   = 2 * NARROW_W,
  parameter int unsigned EMP_IN_W = $clog2(NARROW_W/8),
  parameter int unsigned EMP_OUT_W = EMP_IN_W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_rd_avail,
  output logic                 in_wr_room,
  output logic                 in_rd_en,
  input  logic                 in_wr_en,
  input  logic                 in_sop,
  input  logic                 in_eop,
  input  logic                 in_err,
  input  logic [NARROW_W-1:0]  in_data,
  input  logic [EMP_IN_W-1:0]  in_empty,
  input  logic [CHAN_W-1:0]    in_addr,
  output logic                 out_rd_avail,
  input  logic                 out_wr_room,
  input  logic                 out_rd_en,
  output logic                 out_wr_en,
  output logic                 out_sop,
  output logic                 out_eop,
  output logic                 out_err,
  output logic [WIDE_W-1:0]    out_data,
  output logic [EMP_OUT_W-1:0] out_empty,
  output logic [CHAN_W-1:0]    out_addr
);

  assign out_rd_avail = in_rd_avail;
  assign in_wr_room   = out_wr_room;
  assign in_rd_en     = out_rd_en;

  logic                 ce;
  assign ce = out_rd_en;

  slot_e                slot;
  logic [NARROW_W-1:0]  h_data;
  logic                 h_sop, h_err;
  logic [CHAN_W-1:0]    h_addr;
  logic                 take, drop, emit, mismatch, pend;
  logic [WIDE_W-1:0]    w_data;
  logic                 w_sop, w_eop, w_err;
  logic [EMP_OUT_W-1:0] w_empty;
  logic [CHAN_W-1:0]    w_addr;

  upsz_half_store #(.DW(NARROW_W), .AW(CHAN_W)) u_store (
    .clk(clk), .rst(rst), .ce(ce), .take(take), .drop(drop),
    .d_data(in_data), .d_sop(in_sop), .d_err(in_err), .d_addr(in_addr),
    .slot(slot), .h_data(h_data), .h_sop(h_sop), .h_err(h_err), .h_addr(h_addr)
  );

  upsz_word_build #(.DW(NARROW_W), .AW(CHAN_W), .EWI(EMP_IN_W), .EWO(EMP_OUT_W)) u_build (
    .beat_vld(in_wr_en), .b_data(in_data), .b_sop(in_sop), .b_eop(in_eop),
    .b_err(in_err), .b_empty(in_empty), .b_addr(in_addr),
    .slot(slot), .h_data(h_data), .h_sop(h_sop), .h_err(h_err), .h_addr(h_addr),
    .pend(pend), .take(take), .drop(drop), .emit(emit), .mismatch(mismatch),
    .w_data(w_data), .w_sop(w_sop), .w_eop(w_eop), .w_err(w_err),
    .w_empty(w_empty), .w_addr(w_addr)
  );

  upsz_err_track #(.STICKY(STICKY)) u_err (
    .clk(clk), .rst(rst), .ce(ce), .mismatch(mismatch), .emit(emit), .pend(pend)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_wr_en <= 1'b0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_err   <= 1'b0;
      out_empty <= '0;
      out_addr  <= '0;
      out_data  <= '0;
    end else if (ce) begin
      out_wr_en <= emit;
      if (emit) begin
        out_sop   <= w_sop;
        out_eop   <= w_eop;
        out_err   <= w_err;
        out_empty <= w_empty;
        out_addr  <= w_addr;
        out_data  <= w_data;
      end
    end
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !out_rd_en |=> ($stable(out_wr_en) && $stable(out_data) && $stable(out_eop)
                    && $stable(out_err) && $stable(out_empty)));

  p_idle_r12: assert property (@(posedge clk) disable iff (rst)
    (out_rd_en && !in_wr_en) |=> !out_wr_en);

  p_flush_r6: assert property (@(posedge clk) disable iff (rst)
    (out_rd_en && in_wr_en && in_eop && slot == SLOT_OPEN) |=> (out_wr_en && out_eop));

  p_mismatch_r8: assert property (@(posedge clk) disable iff (rst)
    (out_rd_en && in_wr_en && slot == SLOT_HELD && in_addr != h_addr)
      |=> (out_err && out_eop));

  p_restart_r11: assert property (@(posedge clk) disable iff (rst)
    (out_rd_en && in_wr_en && slot == SLOT_HELD) |=> (out_wr_en && slot == SLOT_OPEN));

  p_first_half_r4: assert property (@(posedge clk) disable iff (rst)
    (out_rd_en && in_wr_en && !in_eop && slot == SLOT_OPEN) |=> !out_wr_en);

endmodule

// File: tb/pkt_upsizer_test.sv
module pkt_upsizer_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_rd_avail = 1'b0, out_wr_room = 1'b0, out_rd_en = 1'b1;
  logic         in_wr_en = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_err = 1'b0;
  logic [63:0]  in_data = '0;
  logic [2:0]   in_empty = '0;
  logic [7:0]   in_addr = '0;
  logic         in_wr_room, in_rd_en, out_rd_avail;
  logic         out_wr_en, out_sop, out_eop, out_err;
  logic [127:0] out_data;
  logic [3:0]   out_empty;
  logic [7:0]   out_addr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  localparam logic [63:0] DA = 64'h1111_2222_3333_4444;
  localparam logic [63:0] DB = 64'hAAAA_BBBB_CCCC_DDDD;
  localparam logic [63:0] DC = 64'h5555_6666_7777_8888;
  localparam logic [63:0] DD = 64'h9999_0000_EEEE_FFFF;

  always #5 clk = ~clk;

  pkt_upsizer uut (
    .clk(clk), .rst(rst),
    .in_rd_avail(in_rd_avail), .in_wr_room(in_wr_room), .in_rd_en(in_rd_en),
    .in_wr_en(in_wr_en), .in_sop(in_sop), .in_eop(in_eop), .in_err(in_err),
    .in_data(in_data), .in_empty(in_empty), .in_addr(in_addr),
    .out_rd_avail(out_rd_avail), .out_wr_room(out_wr_room), .out_rd_en(out_rd_en),
    .out_wr_en(out_wr_en), .out_sop(out_sop), .out_eop(out_eop), .out_err(out_err),
    .out_data(out_data), .out_empty(out_empty), .out_addr(out_addr)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // Offer one beat at a falling edge; results are visible at the next falling edge.
  task automatic beat(input logic s, input logic e, input logic er,
                      input logic [2:0] emp, input logic [7:0] ad, input logic [63:0] d);
    in_wr_en = 1'b1; in_sop = s; in_eop = e; in_err = er;
    in_empty = emp; in_addr = ad; in_data = d;
    @(negedge clk);
    in_wr_en = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_err = 1'b0;
  endtask

  task automatic idle();
    in_wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R13 wr_en after reset", out_wr_en, 0);
    chk("R13 eop after reset", out_eop, 0);
    chk("R13 err after reset", out_err, 0);
    chk("R13 empty after reset", out_empty, 0);
    beat(1, 0, 0, 0, 8'h01, DA);
    chk("R13 slot empty after reset", out_wr_en, 0);
    beat(0, 0, 0, 0, 8'h01, DB);
    chk("R13 pair completes", out_wr_en, 1);
  endtask

  task automatic t_passthrough();
    in_rd_avail = 1'b1; out_wr_room = 1'b0; #1;
    chk("R1 rd_avail high", out_rd_avail, 1);
    chk("R1 wr_room low", in_wr_room, 0);
    in_rd_avail = 1'b0; out_wr_room = 1'b1; #1;
    chk("R1 rd_avail low", out_rd_avail, 0);
    chk("R1 wr_room high", in_wr_room, 1);
    out_rd_en = 1'b0; #1;
    chk("R2 rd_en low", in_rd_en, 0);
    out_rd_en = 1'b1; #1;
    chk("R2 rd_en high", in_rd_en, 1);
    @(negedge clk);
  endtask

  task automatic t_pair();
    beat(1, 0, 0, 0, 8'h05, DA);
    chk("R4 first half no write", out_wr_en, 0);
    beat(0, 0, 0, 0, 8'h05, DB);
    chk("R5 write", out_wr_en, 1);
    chk("R5 data", out_data, {DA, DB});
    chk("R5 sop", out_sop, 1);
    chk("R5 addr", out_addr, 8'h05);
    chk("R7 no eop", out_eop, 0);
    chk("R7 empty zero", out_empty, 0);
    chk("R9 clean err", out_err, 0);
  endtask

  task automatic t_idle();
    idle();
    chk("R12 idle no write", out_wr_en, 0);
  endtask

  task automatic t_eop_lower();
    beat(0, 0, 0, 0, 8'h05, DC);
    beat(0, 1, 0, 3'd3, 8'h05, DD);
    chk("R7 eop lower write", out_wr_en, 1);
    chk("R7 eop lower flag", out_eop, 1);
    chk("R7 eop lower empty", out_empty, 3);
    chk("R7 sop from upper", out_sop, 0);
  endtask

  task automatic t_flush();
    beat(1, 1, 0, 3'd5, 8'h07, DC);
    chk("R6 flush write", out_wr_en, 1);
    chk("R6 flush data", out_data, {DC, 64'h0});
    chk("R6 flush eop", out_eop, 1);
    chk("R6 flush empty", out_empty, 13);
    chk("R6 flush addr", out_addr, 8'h07);
    beat(1, 0, 0, 0, 8'h08, DA);
    chk("R11 restart upper", out_wr_en, 0);
    beat(0, 0, 0, 0, 8'h08, DB);
    chk("R11 pair after flush", out_data, {DA, DB});
  endtask

  task automatic t_hold();
    beat(1, 0, 0, 0, 8'h02, DA);
    beat(0, 0, 0, 0, 8'h02, DB);
    chk("R3 setup write", out_wr_en, 1);
    out_rd_en = 1'b0;
    beat(1, 1, 1, 3'd2, 8'h09, DD);
    chk("R3 wr held", out_wr_en, 1);
    chk("R3 data held", out_data, {DA, DB});
    chk("R3 eop held", out_eop, 0);
    chk("R3 err held", out_err, 0);
    out_rd_en = 1'b1;
    idle();
    chk("R3 idle after hold", out_wr_en, 0);
    beat(1, 0, 0, 0, 8'h03, DC);
    chk("R3 beat not consumed", out_wr_en, 0);
    beat(0, 0, 0, 0, 8'h03, DA);
    chk("R3 next pair clean", out_data, {DC, DA});
  endtask

  task automatic t_in_err();
    beat(1, 0, 1, 0, 8'h04, DA);
    beat(0, 0, 0, 0, 8'h04, DB);
    chk("R9 err upper", out_err, 1);
    beat(0, 0, 0, 0, 8'h04, DA);
    beat(0, 0, 1, 0, 8'h04, DB);
    chk("R9 err lower", out_err, 1);
    beat(0, 0, 0, 0, 8'h04, DA);
    beat(0, 0, 0, 0, 8'h04, DB);
    chk("R9 err clears", out_err, 0);
  endtask

  task automatic t_mismatch();
    beat(0, 0, 0, 0, 8'h01, DA);
    beat(1, 0, 0, 0, 8'h02, DB);
    chk("R8 write", out_wr_en, 1);
    chk("R8 err", out_err, 1);
    chk("R8 eop", out_eop, 1);
    beat(0, 0, 0, 0, 8'h02, DC);
    chk("R11 after mismatch", out_wr_en, 0);
    beat(0, 0, 0, 0, 8'h02, DD);
    chk("R10 sticky err", out_err, 1);
    chk("R10 no eop", out_eop, 0);
    beat(0, 0, 0, 0, 8'h02, DA);
    beat(0, 0, 0, 0, 8'h02, DB);
    chk("R10 sticky clears", out_err, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_passthrough();
    t_pair();
    t_idle();
    t_eop_lower();
    t_flush();
    t_hold();
    t_in_err();
    t_mismatch();
    idle();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule